// File: doc/BRIEF.md
# Idle-Triggered Self-Refresh Controller

This block sits on the request side of a DRAM controller and decides when the memory should drop into self refresh and when it must come back out. It counts consecutive cycles in which the controller reports itself idle and no transaction is being offered. Once that run reaches a length chosen by a 4-bit code, it issues a one-cycle enter command. Software can also ask for self refresh directly through a request level.

When a transaction shows up while the memory is in self refresh, the block issues a one-cycle exit command. It then holds the transaction back with a stall output for a fixed wake-up delay before releasing it. The threshold code selects a power of two, 2^(8+2·code) cycles, for codes 1 to 11. Code zero and codes 12 to 15 turn automatic entry off.

The threshold code also decides how a software-requested self refresh ends. With a usable code, any transaction ends it. With a zero or reserved code, only the release of the software request ends it.

Top module: `sr_idle_ctrl`

## Requirements
- R1: After reset, sr_enter, sr_exit, sr_active and txn_stall are all low.
- R2: With sr_en high and thr_code c in 1..11, sr_active rises after exactly 2^(8+2c) consecutive cycles with ctl_idle high and txn_valid low. The count starts at the first such cycle, so code 1 gives 1024 and code 2 gives 4096.
- R3: sr_enter is high for exactly one cycle, the first cycle in which sr_active is high.
- R4: A cycle with txn_valid high or ctl_idle low clears the idle run, and counting restarts from zero after it.
- R5: thr_code 0, and thr_code 12 through 15, never cause automatic entry, however long the idle run lasts.
- R6: With sr_en low, a non-zero valid thr_code causes no automatic entry.
- R7: A transaction offered in the very cycle in which the idle run would complete blocks that entry.
- R8: With thr_code in 1..11, txn_valid during self refresh gives a one-cycle sr_exit pulse in the next cycle, and sr_active drops in that same cycle.
- R9: txn_stall is high throughout self refresh, during the sr_exit cycle, and for the 8 cycles that follow it. It is low in the 9th cycle after the exit pulse.
- R10: With ctl_idle high and txn_valid low, raising sw_sr_req enters self refresh in the next cycle, whatever thr_code and sr_en are.
- R11: With thr_code 0 or 12..15, a software-entered self refresh ignores txn_valid and exits one cycle after sw_sr_req is released.
- R12: With thr_code in 1..11, a software-entered self refresh exits on txn_valid even while sw_sr_req stays high.
- R13: No entry of either kind occurs while ctl_idle is low or txn_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Active-low reset |
| thr_code | input | 4 | Idle threshold selector; 1..11 gives 2^(8+2·code) cycles, other values disable automatic entry |
| sr_en | input | 1 | Permits automatic entry |
| txn_valid | input | 1 | A transaction is being offered to the controller |
| sw_sr_req | input | 1 | Software self-refresh request level |
| ctl_idle | input | 1 | Controller has no work in flight |
| sr_enter | output | 1 | One-cycle self-refresh enter command |
| sr_exit | output | 1 | One-cycle self-refresh exit command |
| sr_active | output | 1 | Memory is in self refresh |
| txn_stall | output | 1 | Hold the offered transaction |

## Verification
Automatic entry is driven with unbroken idle runs under two different codes. This shows that the exponent follows the code and that the threshold is exact, not off by one. Runs that are cut by a transaction, by a drop of ctl_idle, or by a transaction landing exactly on the final cycle show that the count clears and that a transaction takes priority over entry.

Long idle runs under code 0, reserved codes and a cleared enable show that entry stays disabled. Software entries under a zero code and under a valid code show the two different exit rules.

// File: rtl/sr_idle_pkg.sv
package sr_idle_pkg;
   typedef enum logic [1:0] {
      SR_RUN  = 2'd0,
      SR_SELF = 2'd1,
      SR_WAKE = 2'd2
   } sr_state_e;
endpackage

// File: rtl/sr_thresh_dec.sv
module sr_thresh_dec #(
   parameter int CODE_W   = 4,
   parameter int CNT_W    = 31,
   parameter int BASE_EXP = 8,
   parameter int EXP_STEP = 2,
   parameter int CODE_MIN = 1,
   parameter int CODE_MAX = 11
) (
   input  logic [CODE_W-1:0] code,
   output logic              code_ok,
   output logic [CNT_W-1:0]  limit_m1
);
   localparam int TOP_EXP = BASE_EXP + EXP_STEP * CODE_MAX;
   localparam int EXP_W   = $clog2(TOP_EXP + 1);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   generate
      if (TOP_EXP >= CNT_W) begin : g_bad_width
         $error("sr_thresh_dec: counter too narrow for largest threshold");
      end
      if (CODE_MIN < 1 || CODE_MAX >= (1 << CODE_W)) begin : g_bad_range
         $error("sr_thresh_dec: code range does not fit the code field");
      end
   endgenerate

   logic [EXP_W-1:0] exp_v;

   always_comb begin
      code_ok  = (int'(code) >= CODE_MIN) && (int'(code) <= CODE_MAX);
      exp_v    = EXP_W'(BASE_EXP + EXP_STEP * int'(code));
      limit_m1 = code_ok ? ((ONE << exp_v) - ONE) : '1;
   end
endmodule

// File: rtl/sr_idle_cnt.sv
module sr_idle_cnt #(
   parameter int CNT_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] limit_m1,
   output logic             at_limit
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (clr)                      cnt_q <= '0;
      else if (inc && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
   end

   assign at_limit = (cnt_q >= limit_m1);

   // saturating run length never wraps past the threshold (R2)
   assert_cnt_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && inc && !clr) |=> (cnt_q == CNT_MAX));

   // a clearing cycle restarts the run from zero (R4)
   assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
endmodule

// File: rtl/sr_fsm.sv
module sr_fsm
   import sr_idle_pkg::*;
#(
   parameter int EXIT_DLY = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      auto_go,
   input  logic      sw_go,
   input  logic      wake,
   output sr_state_e state,
   output logic      sr_enter,
   output logic      sr_exit
);
   localparam int DLY_W = $clog2(EXIT_DLY + 1);
   localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(EXIT_DLY);

   generate
      if (EXIT_DLY < 1) begin : g_bad_dly
         $error("sr_fsm: exit delay must be at least one cycle");
      end
   endgenerate

   sr_state_e        nxt;
   logic [DLY_W-1:0] dly_q;

   always_comb begin
      nxt = state;
      unique case (state)
         SR_RUN:  if (auto_go || sw_go) nxt = SR_SELF;
         SR_SELF: if (wake)             nxt = SR_WAKE;
         SR_WAKE: if (dly_q == DLY_LAST) nxt = SR_RUN;
         default: nxt = SR_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SR_RUN;
         dly_q    <= '0;
         sr_enter <= 1'b0;
         sr_exit  <= 1'b0;
      end else begin
         state    <= nxt;
         dly_q    <= (state == SR_WAKE) ? dly_q + 1'b1 : '0;
         sr_enter <= (state == SR_RUN)  && (nxt == SR_SELF);
         sr_exit  <= (state == SR_SELF) && (nxt == SR_WAKE);
      end
   end

   // enter command lasts one cycle (R3)
   assert_enter_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sr_enter |=> !sr_enter);

   // exit command follows a wake request seen in self refresh (R8)
   assert_exit_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sr_exit |-> ($past(state) == SR_SELF) && $past(wake));

   // wake-up delay is not cut short (R9)
   assert_wake_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SR_WAKE && dly_q != DLY_LAST) |=> (state == SR_WAKE));
endmodule

// File: rtl/sr_idle_ctrl.sv
module sr_idle_ctrl
   import sr_idle_pkg::*;
#(
   parameter int CODE_W   = 4,
   parameter int CNT_W    = 31,
   parameter int BASE_EXP = 8,
   parameter int EXP_STEP = 2,
   parameter int CODE_MIN = 1,
   parameter int CODE_MAX = 11,
   parameter int EXIT_DLY = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] thr_code,
   input  logic              sr_en,
   input  logic              txn_valid,
   input  logic              sw_sr_req,
   input  logic              ctl_idle,
   output logic              sr_enter,
   output logic              sr_exit,
   output logic              sr_active,
   output logic              txn_stall
);
   sr_state_e        state;
   logic             code_ok;
   logic [CNT_W-1:0] limit_m1;
   logic             at_limit;
   logic             quiet;
   logic             cnt_clr;
   logic             auto_go;
   logic             sw_go;
   logic             wake;

   sr_thresh_dec #(
      .CODE_W(CODE_W), .CNT_W(CNT_W), .BASE_EXP(BASE_EXP),
      .EXP_STEP(EXP_STEP), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)
   ) u_dec (
      .code(thr_code), .code_ok(code_ok), .limit_m1(limit_m1)
   );

   assign quiet   = ctl_idle && !txn_valid;
   assign cnt_clr = !quiet || (state != SR_RUN);

   sr_idle_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(quiet),
      .limit_m1(limit_m1), .at_limit(at_limit)
   );

   assign auto_go = quiet && code_ok && sr_en && at_limit;
   assign sw_go   = quiet && sw_sr_req;
   assign wake    = code_ok ? txn_valid : !sw_sr_req;

   sr_fsm #(.EXIT_DLY(EXIT_DLY)) u_fsm (
      .clk(clk), .rst_n(rst_n), .auto_go(auto_go), .sw_go(sw_go),
      .wake(wake), .state(state), .sr_enter(sr_enter), .sr_exit(sr_exit)
   );

   assign sr_active = (state == SR_SELF);
   assign txn_stall = (state != SR_RUN);

   // entry only from a quiet cycle (R13)
   assert_enter_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
      sr_enter |-> $past(ctl_idle) && !$past(txn_valid));

   // unrequested entry needs a usable code and the enable (R5, R6)
   assert_auto_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_enter && !$past(sw_sr_req)) |-> $past(code_ok) && $past(sr_en));

   // with a usable code, leaving is caused by a transaction (R12)
   assert_exit_txn_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_exit && $past(code_ok)) |-> $past(txn_valid));

   // exit command always comes with the stall held (R9)
   assert_exit_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sr_exit |-> txn_stall && !sr_active);
endmodule

// File: tb/sr_idle_ctrl_bench.sv
module sr_idle_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] thr_code = 4'd0;
   logic       sr_en = 1'b0;
   logic       txn_valid = 1'b0;
   logic       sw_sr_req = 1'b0;
   logic       ctl_idle = 1'b1;
   logic       sr_enter, sr_exit, sr_active, txn_stall;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sr_idle_ctrl u_sr_idle_ctrl (
      .clk(clk), .rst_n(rst_n), .thr_code(thr_code), .sr_en(sr_en),
      .txn_valid(txn_valid), .sw_sr_req(sw_sr_req), .ctl_idle(ctl_idle),
      .sr_enter(sr_enter), .sr_exit(sr_exit), .sr_active(sr_active),
      .txn_stall(txn_stall)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // one transaction cycle leaves the run count at zero
   task automatic clear_cnt();
      txn_valid = 1'b1;
      step();
      txn_valid = 1'b0;
   endtask

   task automatic run_idle(input int max, output int n);
      n = 0;
      while (n < max && !sr_active) begin
         step();
         n++;
      end
   endtask

   // transaction wakes the memory; stall window measured
   task automatic txn_exit(input string req);
      txn_valid = 1'b1;
      step();
      check({req, " exit pulse"}, sr_exit, 1);
      check({req, " active low on exit"}, sr_active, 0);
      check("R9 stall on exit cycle", txn_stall, 1);
      for (int k = 1; k <= 9; k++) begin
         step();
         check("R9 stall window", txn_stall, (k < 9) ? 1 : 0);
         if (k == 1) check("R8 exit pulse width", sr_exit, 0);
      end
      txn_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 enter", sr_enter, 0);
      check("R1 exit", sr_exit, 0);
      check("R1 active", sr_active, 0);
      check("R1 stall", txn_stall, 0);
   endtask

   task automatic t_auto(input logic [3:0] code, input int exp);
      int n;
      thr_code = code; sr_en = 1'b1; ctl_idle = 1'b1;
      clear_cnt();
      run_idle(exp + 16, n);
      check("R2 idle cycles to entry", n, exp);
      check("R3 enter pulse with entry", sr_enter, 1);
      check("R9 stall while in self refresh", txn_stall, 1);
      step();
      check("R3 enter pulse one cycle", sr_enter, 0);
      check("R3 active held", sr_active, 1);
      txn_exit("R8");
   endtask

   task automatic t_clear();
      int n;
      thr_code = 4'd1; sr_en = 1'b1;
      clear_cnt();
      repeat (1000) step();
      ctl_idle = 1'b0;
      step();
      ctl_idle = 1'b1;
      run_idle(1100, n);
      check("R4 run restarts after busy cycle", n, 1024);
      txn_exit("R8");
      clear_cnt();
      repeat (700) step();
      clear_cnt();
      run_idle(1100, n);
      check("R4 run restarts after transaction", n, 1024);
      txn_exit("R8");
   endtask

   task automatic t_no_entry(input string req, input logic [3:0] code, input logic en);
      logic seen;
      seen = 1'b0;
      thr_code = code; sr_en = en; ctl_idle = 1'b1;
      clear_cnt();
      repeat (3000) begin
         step();
         seen = seen | sr_enter | sr_active;
      end
      check(req, seen, 0);
   endtask

   task automatic t_same_cycle();
      int n;
      thr_code = 4'd1; sr_en = 1'b1; ctl_idle = 1'b1;
      clear_cnt();
      repeat (1023) step();
      txn_valid = 1'b1;
      step();
      txn_valid = 1'b0;
      check("R7 transaction blocks entry", sr_active, 0);
      check("R7 no enter pulse", sr_enter, 0);
      run_idle(1100, n);
      check("R4 run restarts after blocked entry", n, 1024);
      txn_exit("R8");
   endtask

   task automatic t_sw_zero();
      thr_code = 4'd0; sr_en = 1'b0; ctl_idle = 1'b1;
      sw_sr_req = 1'b1;
      step();
      check("R10 software entry", sr_enter, 1);
      check("R10 software active", sr_active, 1);
      txn_valid = 1'b1;
      repeat (5) begin
         step();
         check("R11 transaction ignored", sr_active, 1);
         check("R11 no exit on transaction", sr_exit, 0);
         check("R9 stall held", txn_stall, 1);
      end
      sw_sr_req = 1'b0;
      step();
      check("R11 exit on release", sr_exit, 1);
      for (int k = 1; k <= 9; k++) begin
         step();
         check("R9 stall window", txn_stall, (k < 9) ? 1 : 0);
      end
      txn_valid = 1'b0;
   endtask

   task automatic t_sw_valid();
      thr_code = 4'd5; sr_en = 1'b0; ctl_idle = 1'b1;
      sw_sr_req = 1'b1;
      step();
      check("R10 software entry despite enable low", sr_active, 1);
      repeat (3) step();
      txn_valid = 1'b1;
      step();
      check("R12 exit with request held", sr_exit, 1);
      sw_sr_req = 1'b0;
      for (int k = 1; k <= 9; k++) begin
         step();
         check("R9 stall window", txn_stall, (k < 9) ? 1 : 0);
      end
      txn_valid = 1'b0;
   endtask

   task automatic t_sw_block();
      thr_code = 4'd0; sr_en = 1'b0;
      ctl_idle = 1'b0; sw_sr_req = 1'b1;
      repeat (4) begin
         step();
         check("R13 no entry while busy", sr_active, 0);
      end
      ctl_idle = 1'b1; txn_valid = 1'b1;
      repeat (3) begin
         step();
         check("R13 no entry with transaction", sr_active, 0);
      end
      txn_valid = 1'b0;
      step();
      check("R13 entry once quiet", sr_enter, 1);
      sw_sr_req = 1'b0;
      step();
      check("R11 exit on release", sr_exit, 1);
      repeat (9) step();
      check("R9 stall released", txn_stall, 0);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_auto(4'd1, 1024);
      t_auto(4'd2, 4096);
      t_clear();
      t_no_entry("R5 code zero never enters", 4'd0, 1'b1);
      t_no_entry("R5 reserved code 12 never enters", 4'd12, 1'b1);
      t_no_entry("R5 reserved code 15 never enters", 4'd15, 1'b1);
      t_no_entry("R6 enable low blocks entry", 4'd1, 1'b0);
      t_same_cycle();
      t_sw_zero();
      t_sw_valid();
      t_sw_block();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule